// File: doc/BRIEF.md
# Timer Interrupt Router

This unit sits between a bank of event timers and the interrupt fabric. Each timer reports fire events and deassert (disarm) events. For every fire, the unit chooses one of three ways to deliver it. A level-mode timer latches a status bit and holds its interrupt line high. An edge-mode timer emits a single-cycle pulse. A timer with message delivery enabled sends a 32-bit memory write instead of touching any line.

A per-timer status register records the level-mode interrupts that are still asserted. Software clears those bits with write-1-to-clear. A legacy mode overrides the route fields of the first two timers and pins them to fixed lines. The same mode also takes over the line that normally carries an external real-time-clock interrupt.

Message writes leave through a valid/ready channel. A request stays on the channel, with address and data unchanged, until ready is seen high at a clock edge. Each fire is counted in a small per-timer counter, so back-pressure delays messages but does not merge them until that counter saturates. Control and status pins are plain levels.

Top module: `tirq_router`

## Requirements
- R1: After reset, `irq_o`, `sts_o` and `msg_valid_o` are all zero.
- R2: A fire on an enabled, level-mode, non-message timer (`tmr_level_i`=1) sets its `sts_o` bit and drives its line high from the next cycle. Both stay high until a deassert event.
- R3: A fire on an edge-mode timer (`tmr_level_i`=0) clears its `sts_o` bit and drives its line high for exactly one cycle, starting the next cycle.
- R4: A timer's line number is its 5-bit route field (`tmr_route_i[5i+4:5i]`). While `legacy_i`=1, timer 0 uses line 0 and timer 1 uses line 8, whatever their route fields hold.
- R5: When several timers map to the same line, that line is the OR of their asserted states.
- R6: Each of the following is a deassert event: `disarm_i`, a cleared timer enable, a cleared `glb_en_i`. A deassert event clears the status bit and drops the line in the next cycle. It wins over a fire in the same cycle.
- R7: A cycle with `sts_wr_i`=1 clears exactly the status bits that are set in both `sts_wr_mask_i` and `sts_o`, and deasserts those timers. Mask bits for clear status bits have no effect.
- R8: A fire on a timer with `tmr_msg_i`=1 drives no line and leaves its status bit alone. It queues a write request. The request's address is bits 63:32 of that timer's message word and its data is bits 31:0.
- R9: `msg_valid_o` with `msg_addr_o` and `msg_data_o` is held stable until `msg_ready_i` is high at an edge. Each fire yields one request. Up to 3 fires are counted per timer and further fires are dropped. The lowest-numbered pending timer is served first.
- R10: A rising edge of a timer's `tmr_msg_i` is a deassert event: its status bit is cleared.
- R11: While `legacy_i`=0, line 8 also carries the `rtc_irq_i` level, registered by one cycle. While `legacy_i`=1 that input has no effect on line 8. Leaving legacy mode restores the current registered level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | NUM_TMR | Per-timer fire event |
| disarm_i | input | NUM_TMR | Per-timer deassert request |
| tmr_en_i | input | NUM_TMR | Per-timer interrupt enable |
| tmr_level_i | input | NUM_TMR | 1 = level mode, 0 = edge mode |
| tmr_msg_i | input | NUM_TMR | Message delivery enable |
| tmr_route_i | input | NUM_TMR*5 | Per-timer line number |
| msg_word_i | input | NUM_TMR*64 | Per-timer message word (address high, data low) |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy line mapping |
| rtc_irq_i | input | 1 | External RTC interrupt level |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wr_mask_i | input | NUM_TMR | Write-1-to-clear mask |
| sts_o | output | NUM_TMR | Interrupt status bits |
| irq_o | output | 32 | Interrupt line vector |
| msg_valid_o | output | 1 | Write request valid |
| msg_ready_i | input | 1 | Write request accepted |
| msg_addr_o | output | 32 | Write address |
| msg_data_o | output | 32 | Write data |

## Verification
If a status bit gets stuck or is lost, it shows on `sts_o` and on the mapped line in the very next cycle after the fire, clear or deassert that should have changed it. A wrong line mapping lights an unexpected bit of `irq_o` on the first fire. A broken pending counter or a broken arbiter only appears once the channel is released. It shows as a missing, duplicated or reordered request on the handshakes after `msg_ready_i` rises. RTC faults show on line 8 one cycle after a change of the input or of legacy mode.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  parameter int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] tirq_word_t;
  typedef struct packed {
    tirq_word_t addr;
    tirq_word_t data;
  } tirq_msg_t;
endpackage

// File: rtl/tirq_slot.sv
module tirq_slot #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic disarm,
  input  logic en,
  input  logic level,
  input  logic msg,
  input  logic glb_en,
  input  logic clr_req,
  input  logic take,
  output logic sts,
  output logic pulse,
  output logic pend
);
  localparam logic [PEND_W-1:0] CNT_MAX = '1;

  logic              msg_q;
  logic [PEND_W-1:0] cnt;
  logic              deas, fire_ok, inc;

  always_comb begin
    deas    = disarm | ~en | ~glb_en | (clr_req & sts) | (msg & ~msg_q);
    fire_ok = fire & ~deas;
    inc     = fire_ok & msg & (cnt != CNT_MAX);
    pend    = (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts   <= 1'b0;
      pulse <= 1'b0;
      msg_q <= 1'b0;
      cnt   <= '0;
    end else begin
      msg_q <= msg;
      pulse <= fire_ok & ~msg & ~level;
      if (deas)
        sts <= 1'b0;
      else if (fire_ok & ~msg)
        sts <= level;
      cnt <= cnt + PEND_W'(inc) - PEND_W'(take);
    end
  end
endmodule

// File: rtl/tirq_msg_arb.sv
module tirq_msg_arb
  import tirq_pkg::*;
#(
  parameter int NUM_TMR = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_TMR-1:0]      pend,
  input  logic [NUM_TMR*64-1:0]   words,
  input  logic                    ready,
  output logic                    valid,
  output tirq_msg_t               req,
  output logic [NUM_TMR-1:0]      take
);
  localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  logic             found, load;
  logic [IDX_W-1:0] idx;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (pend[i] && !found) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    load = ~valid | ready;
    take = (load && found) ? (NUM_TMR'(1) << idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      req   <= '0;
    end else if (load) begin
      valid <= found;
      if (found) req <= words[idx*64 +: 64];
    end
  end
endmodule

// File: rtl/tirq_line_merge.sv
module tirq_line_merge #(
  parameter int NUM_TMR = 4,
  parameter int NUM_IRQ = 32,
  parameter int ROUTE_W = 5,
  parameter int LEG0    = 0,
  parameter int LEG1    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_TMR-1:0]        active,
  input  logic [NUM_TMR*ROUTE_W-1:0] route,
  input  logic                      legacy,
  input  logic                      rtc_in,
  output logic [NUM_IRQ-1:0]        irq
);
  logic rtc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rtc_q <= 1'b0;
    else        rtc_q <= rtc_in;
  end

  always_comb begin
    logic [ROUTE_W-1:0] line;
    irq = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      line = route[i*ROUTE_W +: ROUTE_W];
      if (legacy && i == 0) line = ROUTE_W'(LEG0);
      if (legacy && i == 1) line = ROUTE_W'(LEG1);
      if (active[i]) irq[line] = 1'b1;
    end
    if (!legacy && rtc_q) irq[LEG1] = 1'b1;
  end
endmodule

// File: rtl/tirq_router.sv
module tirq_router
  import tirq_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int PEND_W  = 2,
  parameter int LEG0    = 0,
  parameter int LEG1    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TMR-1:0]   fire_i,
  input  logic [NUM_TMR-1:0]   disarm_i,
  input  logic [NUM_TMR-1:0]   tmr_en_i,
  input  logic [NUM_TMR-1:0]   tmr_level_i,
  input  logic [NUM_TMR-1:0]   tmr_msg_i,
  input  logic [NUM_TMR*5-1:0] tmr_route_i,
  input  logic [NUM_TMR*64-1:0] msg_word_i,
  input  logic                 glb_en_i,
  input  logic                 legacy_i,
  input  logic                 rtc_irq_i,
  input  logic                 sts_wr_i,
  input  logic [NUM_TMR-1:0]   sts_wr_mask_i,
  output logic [NUM_TMR-1:0]   sts_o,
  output logic [31:0]          irq_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [31:0]          msg_addr_o,
  output logic [31:0]          msg_data_o
);
  localparam int NUM_IRQ = 32;
  localparam int ROUTE_W = $clog2(NUM_IRQ);

  logic [NUM_TMR-1:0] pulse, pend, take, active;
  tirq_msg_t          req;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_slot
    tirq_slot #(.PEND_W(PEND_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire_i[g]),
      .disarm  (disarm_i[g]),
      .en      (tmr_en_i[g]),
      .level   (tmr_level_i[g]),
      .msg     (tmr_msg_i[g]),
      .glb_en  (glb_en_i),
      .clr_req (sts_wr_i & sts_wr_mask_i[g]),
      .take    (take[g]),
      .sts     (sts_o[g]),
      .pulse   (pulse[g]),
      .pend    (pend[g])
    );
  end

  assign active = (sts_o & ~tmr_msg_i) | pulse;

  tirq_line_merge #(
    .NUM_TMR(NUM_TMR), .NUM_IRQ(NUM_IRQ), .ROUTE_W(ROUTE_W),
    .LEG0(LEG0), .LEG1(LEG1)
  ) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .route  (tmr_route_i),
    .legacy (legacy_i),
    .rtc_in (rtc_irq_i),
    .irq    (irq_o)
  );

  tirq_msg_arb #(.NUM_TMR(NUM_TMR)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .words (msg_word_i),
    .ready (msg_ready_i),
    .valid (msg_valid_o),
    .req   (req),
    .take  (take)
  );

  assign msg_addr_o = req.addr;
  assign msg_data_o = req.data;
endmodule

// File: rtl/tirq_router_chk.sv
module tirq_router_chk #(
  parameter int NUM_TMR = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_en_i,
  input logic               sts_wr_i,
  input logic [NUM_TMR-1:0] sts_wr_mask_i,
  input logic [NUM_TMR-1:0] sts_o,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [31:0]        msg_addr_o,
  input logic [31:0]        msg_data_o
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o);

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> $stable(msg_addr_o) && $stable(msg_data_o));

  assert_glb_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |=> sts_o == '0);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr_i |=> (sts_o & $past(sts_wr_mask_i & sts_o)) == '0);
endmodule

bind tirq_router tirq_router_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .glb_en_i      (glb_en_i),
  .sts_wr_i      (sts_wr_i),
  .sts_wr_mask_i (sts_wr_mask_i),
  .sts_o         (sts_o),
  .msg_valid_o   (msg_valid_o),
  .msg_ready_i   (msg_ready_i),
  .msg_addr_o    (msg_addr_o),
  .msg_data_o    (msg_data_o)
);

// File: tb/tb_tirq_router.sv
module tb_tirq_router;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    fire_i = '0, disarm_i = '0, tmr_en_i = '0, tmr_level_i = '0, tmr_msg_i = '0;
  logic [N*5-1:0]  tmr_route_i = '0;
  logic [N*64-1:0] msg_word_i = '0;
  logic glb_en_i = 1'b0, legacy_i = 1'b0, rtc_irq_i = 1'b0, sts_wr_i = 1'b0, msg_ready_i = 1'b0;
  logic [N-1:0] sts_wr_mask_i = '0;
  logic [N-1:0] sts_o;
  logic [31:0]  irq_o, msg_addr_o, msg_data_o;
  logic         msg_valid_o;

  tirq_router #(.NUM_TMR(N)) dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [N-1:0] m_sts = '0, m_pulse = '0, m_msgq = '0;
  logic m_rtc = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_irq();
    logic [31:0] v = '0;
    int ln;
    for (int i = 0; i < N; i++) begin
      ln = int'(tmr_route_i[i*5 +: 5]);
      if (legacy_i && i == 0) ln = 0;
      if (legacy_i && i == 1) ln = 8;
      if ((m_sts[i] && !tmr_msg_i[i]) || m_pulse[i]) v[ln] = 1'b1;
    end
    if (!legacy_i && m_rtc) v[8] = 1'b1;
    return v;
  endfunction

  // one clock: model next state from applied inputs, then compare (R5 lines, R6 status)
  task automatic cyc();
    logic [N-1:0] ns, np;
    logic deas, fo;
    for (int i = 0; i < N; i++) begin
      deas = disarm_i[i] | ~tmr_en_i[i] | ~glb_en_i | (sts_wr_i & sts_wr_mask_i[i] & m_sts[i])
             | (tmr_msg_i[i] & ~m_msgq[i]);
      fo = fire_i[i] & ~deas;
      np[i] = fo & ~tmr_msg_i[i] & ~tmr_level_i[i];
      ns[i] = deas ? 1'b0 : ((fo & ~tmr_msg_i[i]) ? tmr_level_i[i] : m_sts[i]);
    end
    @(posedge clk);
    m_sts = ns; m_pulse = np; m_msgq = tmr_msg_i; m_rtc = rtc_irq_i;
    #1;
    check(irq_o == exp_irq(), "R5 line model", 64'(irq_o), 64'(exp_irq()));
    check(sts_o == m_sts, "R6 status model", 64'(sts_o), 64'(m_sts));
  endtask

  task automatic pulse_fire(input logic [N-1:0] f);
    fire_i = f; cyc(); fire_i = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check(irq_o == '0 && sts_o == '0 && !msg_valid_o, "R1 reset",
          {irq_o, 27'd0, sts_o, msg_valid_o}, 64'd0);

    glb_en_i = 1'b1;
    tmr_en_i = '1;
    tmr_route_i[0*5 +: 5] = 5'd5;
    tmr_route_i[1*5 +: 5] = 5'd12;
    tmr_route_i[2*5 +: 5] = 5'd20;
    tmr_route_i[3*5 +: 5] = 5'd20;
    tmr_level_i = 4'b1101;

    // R2 level hold
    pulse_fire(4'b0001);
    check(irq_o[5] && sts_o[0], "R2 level set", {irq_o[5], sts_o[0]}, 2'b11);
    cyc(); cyc();
    check(irq_o[5] == 1'b1, "R2 level held", irq_o[5], 1);

    // R7 write-1-to-clear, bit 1 written but not set
    sts_wr_i = 1'b1; sts_wr_mask_i = 4'b0011; cyc(); sts_wr_i = 1'b0; sts_wr_mask_i = '0;
    check(sts_o == '0 && !irq_o[5], "R7 w1c", {sts_o, irq_o[5]}, 0);

    // R3 edge pulse
    pulse_fire(4'b0010);
    check(irq_o[12] && !sts_o[1], "R3 pulse start", {irq_o[12], sts_o[1]}, 2'b10);
    cyc();
    check(!irq_o[12], "R3 pulse one cycle", irq_o[12], 0);

    // R4 legacy mapping
    legacy_i = 1'b1;
    pulse_fire(4'b0011);
    check(irq_o[8] && irq_o[0] && !irq_o[12] && !irq_o[5], "R4 legacy map",
          64'(irq_o), 64'h101);
    disarm_i = 4'b0001; cyc(); disarm_i = '0;
    legacy_i = 1'b0;

    // R5 shared line OR, R6 disarm
    pulse_fire(4'b1100);
    disarm_i = 4'b0100; cyc(); disarm_i = '0;
    check(irq_o[20] && sts_o == 4'b1000, "R5 shared line", {irq_o[20], sts_o}, 5'b11000);
    disarm_i = 4'b1000; cyc(); disarm_i = '0;
    check(!irq_o[20], "R6 disarm drops", irq_o[20], 0);

    // R6 deassert beats fire; global disable
    fire_i = 4'b0100; disarm_i = 4'b0100; cyc(); fire_i = '0; disarm_i = '0;
    check(!sts_o[2] && !irq_o[20], "R6 priority", {sts_o[2], irq_o[20]}, 0);
    pulse_fire(4'b0001);
    glb_en_i = 1'b0; cyc(); glb_en_i = 1'b1;
    check(sts_o == '0 && irq_o == '0, "R6 global off", {irq_o, 28'd0, sts_o}, 0);

    // R11 RTC pass-through
    rtc_irq_i = 1'b1; cyc();
    check(irq_o[8], "R11 rtc pass", irq_o[8], 1);
    legacy_i = 1'b1; cyc();
    check(!irq_o[8], "R11 rtc blocked", irq_o[8], 0);
    legacy_i = 1'b0; cyc();
    check(irq_o[8], "R11 rtc restored", irq_o[8], 1);
    rtc_irq_i = 1'b0; cyc();
    check(!irq_o[8], "R11 rtc low", irq_o[8], 0);

    // R10 message enable deasserts
    msg_word_i[2*64 +: 64] = {32'hA000_1000, 32'hD000_0002};
    msg_word_i[3*64 +: 64] = {32'hA000_3000, 32'hD000_0003};
    pulse_fire(4'b0100);
    tmr_msg_i = 4'b1100; cyc();
    check(!sts_o[2], "R10 msg on clears", sts_o[2], 0);

    // R8/R9 messages under back-pressure
    pulse_fire(4'b0100);
    pulse_fire(4'b1100);
    check(msg_valid_o && msg_addr_o == 32'hA000_1000 && msg_data_o == 32'hD000_0002,
          "R8 msg addr/data", {msg_valid_o, msg_addr_o}, {1'b1, 32'hA000_1000});
    check(irq_o == '0 && sts_o == '0, "R8 no line", {irq_o, 28'd0, sts_o}, 0);
    cyc(); cyc();
    check(msg_valid_o && msg_addr_o == 32'hA000_1000, "R9 held", {msg_valid_o, msg_addr_o},
          {1'b1, 32'hA000_1000});
    msg_ready_i = 1'b1; cyc();
    check(msg_valid_o && msg_addr_o == 32'hA000_1000, "R9 second fire", 64'(msg_addr_o), 64'hA000_1000);
    cyc();
    check(msg_valid_o && msg_addr_o == 32'hA000_3000 && msg_data_o == 32'hD000_0003,
          "R9 next timer", 64'(msg_addr_o), 64'hA000_3000);
    cyc();
    check(!msg_valid_o, "R9 drained", msg_valid_o, 0);
    tmr_msg_i = '0;
    sts_wr_i = 1'b1; sts_wr_mask_i = '1; cyc(); sts_wr_i = 1'b0; sts_wr_mask_i = '0;

    // random phase, checked each cycle by the model (R2..R7, R11)
    for (int k = 0; k < 2000; k++) begin
      if (k % 16 == 0) begin
        tmr_level_i = N'($urandom);
        tmr_en_i    = N'($urandom | $urandom);
        tmr_msg_i   = N'($urandom & $urandom & $urandom);
        tmr_route_i = (N*5)'({$urandom, $urandom} & 64'h0C63_18C6_318C_6318);
        legacy_i    = ($urandom % 4) == 0;
      end
      fire_i        = N'($urandom & $urandom);
      disarm_i      = N'($urandom & $urandom & $urandom);
      glb_en_i      = ($urandom % 16) != 0;
      rtc_irq_i     = ($urandom % 3) == 0;
      sts_wr_i      = ($urandom % 5) == 0;
      sts_wr_mask_i = N'($urandom);
      msg_ready_i   = $urandom % 2;
      cyc();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule